// File: doc/BRIEF.md
# Spread-Spectrum PWM Carrier Generator

This block produces the switching carrier for a digital class D output stage. The carrier frequency is not fixed. At each carrier cycle, a 5-bit maximal-length shift register selects one of 31 discrete frequency steps, so that the switching energy is spread over a band instead of sitting at one tone.

A period counter divides the system clock down to the selected step. The block drives three outputs:
- the ramp count;
- a one-cycle strobe at the start of each period;
- a PWM output, which is high while the ramp is below a duty-derived threshold scaled to the period now running.

A period choice only takes effect at a period boundary, so no carrier cycle is cut short or lengthened. An enable input freezes the sequence and pins the carrier to a mid-band step, for comparison against fixed-frequency operation.

Top module: `ssc_pwm_carrier`

## Requirements
- R1: `ramp` counts 0, 1, ..., P-1 and then returns to 0, where P is the length of the current period. `start` is high exactly in the cycles where `ramp` is 0.
- R2: Step k (k = 0..30) has a period of round(100e6 / (145000 + 5000*k)) clock cycles, rounding half up. This gives 690 cycles for step 0, 455 cycles for step 15 and 339 cycles for step 30.
- R3: The sequence register s is 5 bits wide and updates as s_next = {s[3:0], s[4]^s[2]}. It is seeded to 1 and selects step s-1. It advances once per period, at the clock edge that ends the `ramp`=0 cycle, and only when `en` is high.
- R4: The next period length is chosen from `en` and the sequence register at the edge where `ramp` wraps to 0. It cannot change during a period, so changes to `en` in the middle of a period do not affect the period now running.
- R5: `duty` is sampled at the edge that starts a period. The threshold is T = (duty*P) >> 8. `pwm` is high while `ramp` < T, so it is high for exactly T cycles of the period. Changes to `duty` in the middle of a period are ignored.
- R6: A duty of 0 keeps `pwm` low for the whole period. A duty of 255 gives floor(255*P/256) high cycles.
- R7: While `en` is low, the sequence register holds its value and the next period uses step 15, which is 455 cycles. When `en` returns high, the sequence resumes from the held state.
- R8: While reset is low, `ramp` is 0, `start` is 1 and `pwm` is 0. The first period after reset uses step 0 (690 cycles) and keeps `pwm` low.
- R9: The sequence register never holds zero. If it is ever found at zero, it is reloaded with the seed.
- R10: Over 31 consecutive enabled periods, all 31 steps are visited, so the 31 period lengths are all different.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | High: frequency hopping on. Low: fixed mid-band step |
| duty | input | 8 | Unsigned duty value, sampled at period start |
| ramp | output | 10 | Carrier ramp count |
| start | output | 1 | One-cycle period-start strobe |
| pwm | output | 1 | Compared PWM output |

## Verification
The assertions assume that `en` and `duty` are synchronous to `clk` and do not change near the sampling edge. They also assume that reset is released only while the ramp sits at zero, which reset itself guarantees. The bench therefore changes every input on the falling clock edge. It also deliberately toggles both `en` and `duty` in the middle of each period and restores them before the wrap, so that the sampling-point rules are exercised without breaking those assumptions.

// File: rtl/ssc_pwm_carrier.sv
module ssc_pwm_carrier #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int F_LO     = 145_000,
  parameter int F_STEP   = 5_000,
  parameter int NSTEPS   = 31,
  parameter int FIX_STEP = 15,
  parameter int CW       = 10,
  parameter int DW       = 8,
  parameter int LW       = 5,
  parameter int SEED     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] duty,
  output logic [CW-1:0] ramp,
  output logic          start,
  output logic          pwm
);
  localparam int SW = $clog2(NSTEPS);
  localparam int PW = CW + DW;

  logic [CW-1:0] per_tab [NSTEPS];
  for (genvar k = 0; k < NSTEPS; k++) begin : g_tab
    assign per_tab[k] = CW'((CLK_HZ + (F_LO + F_STEP*k)/2) / (F_LO + F_STEP*k));
  end

  logic [CW-1:0] cnt, per, thr, nper;
  logic [LW-1:0] lfsr;
  logic [SW-1:0] sel_step;
  logic [PW-1:0] prod;
  logic          wrap, fb;

  assign fb       = lfsr[LW-1] ^ lfsr[LW-3];
  assign sel_step = en ? SW'(lfsr - 1'b1) : SW'(FIX_STEP);
  assign nper     = per_tab[sel_step];
  assign prod     = PW'(duty) * PW'(nper);
  assign wrap     = (cnt == per - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      per  <= per_tab[SEED-1];
      thr  <= '0;
      lfsr <= LW'(SEED);
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        per <= nper;
        thr <= prod[PW-1:DW];
      end
      if (lfsr == '0)
        lfsr <= LW'(SEED);
      else if (cnt == '0 && en)
        lfsr <= {lfsr[LW-2:0], fb};
    end
  end

  assign ramp  = cnt;
  assign start = (cnt == '0);
  assign pwm   = (cnt < thr);
endmodule

// File: rtl/ssc_pwm_carrier_chk.sv
module ssc_pwm_carrier_chk #(
  parameter int CW = 10,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          start,
  input logic          pwm,
  input logic [CW-1:0] ramp,
  input logic [CW-1:0] per,
  input logic [LW-1:0] lfsr
);
  // R1
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp != '0) |-> ramp == CW'($past(ramp) + 1'b1));
  // R1
  ramp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp < per);
  // R4
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp != per - 1'b1) |=> $stable(per));
  // R3
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(lfsr));
  // R7
  lfsr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(lfsr));
  // R9
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
  // R5
  pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm) |-> start);
endmodule

bind ssc_pwm_carrier ssc_pwm_carrier_chk #(.CW(CW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .start(start), .pwm(pwm),
  .ramp(ramp), .per(per), .lfsr(lfsr)
);

// File: tb/ssc_pwm_carrier_tb.sv
module ssc_pwm_carrier_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [7:0] duty = 8'd0;
  logic [9:0] ramp;
  logic start, pwm;

  always #10 clk = ~clk;

  ssc_pwm_carrier u_dut (.clk(clk), .rst_n(rst_n), .en(en), .duty(duty),
                         .ramp(ramp), .start(start), .pwm(pwm));

  localparam int NV = 12;
  localparam logic [8:0] VEC [NV] = '{
    9'h100, 9'h180, 9'h1FF, 9'h140, 9'h0C8, 9'h00A,
    9'h101, 9'h180, 9'h1FF, 9'h000, 9'h14D, 9'h1B4};

  int checks = 0, fails = 0;
  int mlfsr, exp_per, exp_thr;
  bit done = 0;

  function automatic int tab(int k);
    int f = 145000 + 5000*k;
    return (100000000 + f/2) / f;
  endfunction

  function automatic int nxt(int s);
    return ((s << 1) & 30) | (((s >> 4) ^ (s >> 2)) & 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart_model();
    mlfsr = 1; exp_per = tab(0); exp_thr = 0;
  endtask

  task automatic do_period(input bit en_v, input int duty_v, output int len);
    int nper, nthr, highs, rbad;
    en = en_v; duty = 8'(duty_v);
    if (en_v) mlfsr = nxt(mlfsr);
    nper = en_v ? tab(mlfsr-1) : tab(15);
    nthr = (duty_v * nper) >> 8;
    len = 0; highs = 0; rbad = 0;
    do begin
      if (ramp != 10'(len)) rbad++;
      if (pwm) highs++;
      if (len == 50)  begin en = ~en_v; duty = ~8'(duty_v); end
      if (len == 100) begin en = en_v;  duty = 8'(duty_v);  end
      @(negedge clk);
      len++;
    end while (!start && len < 2000);
    chk(len == exp_per, "R2/R3/R4/R7 period length", len, exp_per);
    chk(highs == exp_thr, "R5/R6 pwm high cycles", highs, exp_thr);
    chk(rbad == 0, "R1 ramp sequence mismatches", rbad, 0);
    exp_per = nper; exp_thr = nthr;
  endtask

  task automatic reset_check();
    chk(ramp == 0, "R8 reset ramp", ramp, 0);
    chk(start == 1'b1, "R8 reset start", start, 1);
    chk(pwm == 1'b0, "R8 reset pwm", pwm, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int len;
    int lens [31];
    repeat (3) @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    restart_model();
    for (int i = 0; i < NV; i++) do_period(VEC[i][8], int'(VEC[i][7:0]), len);

    // R10: 31 consecutive enabled selections give 31 different lengths
    do_period(1'b1, 100, len);
    for (int i = 0; i < 31; i++) begin
      do_period(1'b1, 100, len);
      lens[i] = len;
    end
    begin
      int dup = 0;
      for (int i = 0; i < 31; i++)
        for (int j = i + 1; j < 31; j++)
          if (lens[i] == lens[j]) dup++;
      chk(dup == 0, "R10 duplicate period lengths", dup, 0);
    end

    // R8: reset in mid period
    repeat (123) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    reset_check();
    en = 1'b1;
    rst_n = 1'b1;
    restart_model();
    do_period(1'b1, 255, len);
    do_period(1'b0, 128, len);
    do_period(1'b1, 0, len);
    do_period(1'b1, 10, len);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule